// File: doc/BRIEF.md
# Endpoint Configuration and Buffer Allocator

This block keeps the configuration of sixteen endpoints and carves a shared packet-buffer memory into one region per endpoint, in hardware. Firmware writes one configuration word per endpoint, strictly in index order, starting at index 0. Each word carries an enable bit, a direction bit and a maximum packet size. As each word is accepted, the block stores it and gives the endpoint the next free stretch of buffer. A disabled endpoint gets zero bytes.

Endpoint 0 is the control endpoint. It is fixed and always enabled, with a region of `CTRL_MPS` bytes at address 0. The fields of a word written to index 0 are ignored. That write only restarts the sequence. The block reports `cfg_done` once the last index is accepted cleanly. It reports a sticky `cfg_err` when a write arrives out of order or when the regions would not fit in the buffer. Firmware uses these two flags to choose between an empty acknowledge packet and a stall. The allocation of the non-control endpoints is presented on the outputs only when the sequence is complete and the device reports itself enumerated. A hardware reset or a bus reset clears every non-control register.

Top module: `ep_fifo_alloc`

## Requirements
- R1: After `rst_n` low or a one-cycle `bus_rst` pulse, `cfg_done` and `cfg_err` are 0 and only `ep_en[0]` is set. Endpoint 0 always shows base 0 and size `CTRL_MPS` (64).
- R2: A write to index 0 clears `cfg_err` and `cfg_done` and makes index 1 the next expected index. Its enable, direction and size fields have no effect on endpoint 0.
- R3: Endpoint k (k ≥ 1) gets a base equal to the base of k-1 plus the size of k-1. Endpoint 1 starts at `CTRL_MPS`.
- R4: An endpoint written with enable 0 shows enable 0 and size 0, whatever its size field holds, and it takes no buffer space.
- R5: `cfg_done` rises in the cycle after index 15 is accepted, provided no error is pending. It stays 0 while the sequence is still incomplete.
- R6: A write with a nonzero index other than the next expected one sets `cfg_err` and clears `cfg_done`. This includes any nonzero index written after the sequence has completed.
- R7: A write whose region would end beyond `BUF_BYTES` (2048) sets `cfg_err`.
- R8: The outputs for endpoints 1 to 15 (enable, direction, base and size) read 0 unless `cfg_done` is 1 and `enumerated` is 1.
- R9: When the outputs are presented, `ep_dir[k]` equals the direction bit written for an enabled endpoint. A value of 1 means IN.
- R10: Once set, `cfg_err` stays set until either a write to index 0 or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Synchronous USB bus reset pulse |
| enumerated | input | 1 | Device has been enumerated |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_idx | input | 4 | Endpoint index of the write |
| cfg_en | input | 1 | Endpoint enable field |
| cfg_dir | input | 1 | Direction field, 1 = IN |
| cfg_mps | input | 10 | Maximum packet size in bytes |
| ep_en | output | 16 | Per-endpoint enable |
| ep_dir | output | 16 | Per-endpoint direction |
| ep_base | output | 192 | Per-endpoint base address, 12 bits each, endpoint k at bits k*12 |
| ep_size | output | 160 | Per-endpoint region size, 10 bits each, endpoint k at bits k*10 |
| cfg_done | output | 1 | Sequence accepted with no error |
| cfg_err | output | 1 | Sticky order or capacity error |

## Verification
The assertions assume that `bus_rst` is a synchronous pulse. They also assume that `cfg_idx` and the field inputs are stable whenever `cfg_wr` is high. The bench drives every input on the falling clock edge, and it holds each write strobe for exactly one cycle. Because the bench raises `enumerated` only after a sequence has been checked, the gated outputs are observed both while hidden and while presented.

// File: rtl/ep_fifo_alloc.sv
module ep_fifo_alloc #(
  parameter int NUM_EP    = 16,
  parameter int MPS_W     = 10,
  parameter int BUF_BYTES = 2048,
  parameter int CTRL_MPS  = 64,
  localparam int IDX_W    = $clog2(NUM_EP),
  localparam int ADDR_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_rst,
  input  logic                       enumerated,
  input  logic                       cfg_wr,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic                       cfg_en,
  input  logic                       cfg_dir,
  input  logic [MPS_W-1:0]           cfg_mps,
  output logic [NUM_EP-1:0]          ep_en,
  output logic [NUM_EP-1:0]          ep_dir,
  output logic [NUM_EP*ADDR_W-1:0]   ep_base,
  output logic [NUM_EP*MPS_W-1:0]    ep_size,
  output logic                       cfg_done,
  output logic                       cfg_err
);

  logic [MPS_W-1:0]  sz_q   [1:NUM_EP-1];
  logic [ADDR_W-1:0] base_q [1:NUM_EP-1];
  logic [NUM_EP-1:1] en_q, dir_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W:0]    exp_q;
  logic              done_q, err_q;

  wire [MPS_W-1:0] wr_size  = cfg_en ? cfg_mps : '0;
  wire [ADDR_W:0]  nxt_end  = {1'b0, ptr_q} + (ADDR_W+1)'(wr_size);
  wire             fits     = nxt_end <= (ADDR_W+1)'(BUF_BYTES);
  wire             in_order = {1'b0, cfg_idx} == exp_q;
  wire             restart  = cfg_wr && cfg_idx == '0;
  wire             last_idx = cfg_idx == IDX_W'(NUM_EP-1);
  wire             show     = done_q && enumerated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < NUM_EP; k++) begin
        sz_q[k]   <= '0;
        base_q[k] <= '0;
      end
      en_q   <= '0;
      dir_q  <= '0;
      ptr_q  <= ADDR_W'(CTRL_MPS);
      exp_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (bus_rst || restart) begin
      for (int k = 1; k < NUM_EP; k++) begin
        sz_q[k]   <= '0;
        base_q[k] <= '0;
      end
      en_q   <= '0;
      dir_q  <= '0;
      ptr_q  <= ADDR_W'(CTRL_MPS);
      exp_q  <= bus_rst ? '0 : (IDX_W+1)'(1);
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (cfg_wr && !err_q) begin
      if (in_order && fits) begin
        sz_q[cfg_idx]   <= wr_size;
        base_q[cfg_idx] <= ptr_q;
        en_q[cfg_idx]   <= cfg_en;
        dir_q[cfg_idx]  <= cfg_dir;
        ptr_q           <= nxt_end[ADDR_W-1:0];
        exp_q           <= exp_q + 1'b1;
        if (last_idx) done_q <= 1'b1;
      end else begin
        err_q  <= 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    if (k == 0) begin : g_ctrl
      assign ep_en[0]            = 1'b1;
      assign ep_dir[0]           = 1'b0;
      assign ep_base[0 +: ADDR_W] = '0;
      assign ep_size[0 +: MPS_W]  = MPS_W'(CTRL_MPS);
    end else begin : g_data
      assign ep_en[k]                 = show & en_q[k];
      assign ep_dir[k]                = show & en_q[k] & dir_q[k];
      assign ep_base[k*ADDR_W +: ADDR_W] = show ? base_q[k] : '0;
      assign ep_size[k*MPS_W +: MPS_W]   = show ? sz_q[k] : '0;
    end
  end

  assign cfg_done = done_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/ep_fifo_alloc_chk.sv
module ep_fifo_alloc_chk #(
  parameter int NUM_EP = 16,
  localparam int IDX_W = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst,
  input logic              enumerated,
  input logic              cfg_wr,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [NUM_EP-1:0] ep_en,
  input logic              cfg_done,
  input logic              cfg_err
);

  AST_BUS_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !cfg_done && !cfg_err); // R1

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == '0) |=> !cfg_done && !cfg_err); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_wr) && $past(cfg_idx) == IDX_W'(NUM_EP-1)); // R5

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_done && cfg_err)); // R6

  AST_HIDDEN_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_done && enumerated) |-> ep_en[NUM_EP-1:1] == '0); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !bus_rst && !(cfg_wr && cfg_idx == '0)) |=> cfg_err); // R10

endmodule

bind ep_fifo_alloc ep_fifo_alloc_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .enumerated(enumerated),
  .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .ep_en(ep_en),
  .cfg_done(cfg_done), .cfg_err(cfg_err)
);

// File: tb/tb_ep_fifo_alloc.sv
module tb_ep_fifo_alloc;
  logic clk = 0, rst_n = 0, bus_rst = 0, enumerated = 0;
  logic cfg_wr = 0, cfg_en = 0, cfg_dir = 0;
  logic [3:0] cfg_idx = 0;
  logic [9:0] cfg_mps = 0;
  logic [15:0] ep_en, ep_dir;
  logic [191:0] ep_base;
  logic [159:0] ep_size;
  logic cfg_done, cfg_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ep_fifo_alloc dut (.*);

  // {enable, direction, max packet size} for endpoints 1..15
  localparam logic [11:0] VEC [15] = '{
    {1'b1,1'b0,10'd64},  {1'b1,1'b1,10'd64},  {1'b0,1'b1,10'd200},
    {1'b1,1'b0,10'd128}, {1'b1,1'b1,10'd32},  {1'b1,1'b0,10'd512},
    {1'b1,1'b1,10'd8},   {1'b1,1'b0,10'd16},  {1'b1,1'b1,10'd64},
    {1'b0,1'b0,10'd100}, {1'b1,1'b0,10'd256}, {1'b1,1'b1,10'd64},
    {1'b1,1'b0,10'd16},  {1'b1,1'b1,10'd32},  {1'b1,1'b0,10'd64}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(input int idx, input bit en, input bit dir, input int mps);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_dir = dir; cfg_mps = 10'(mps);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1;
    @(negedge clk); bus_rst = 0;
  endtask

  task automatic ctrl_check(input string tag);
    eq({tag, " ep0 enable"}, int'(ep_en[0]), 1);
    eq({tag, " ep0 base"}, int'(ep_base[11:0]), 0);
    eq({tag, " ep0 size"}, int'(ep_size[9:0]), 64);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ptr;
    int ebase [1:15];
    int esize [1:15];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    eq("R1 reset done", int'(cfg_done), 0);
    eq("R1 reset err", int'(cfg_err), 0);
    eq("R1 reset enables", int'(ep_en), 1);
    ctrl_check("R1 reset");

    ptr = 64;
    for (int i = 1; i <= 15; i++) begin
      ebase[i] = ptr;
      esize[i] = VEC[i-1][11] ? int'(VEC[i-1][9:0]) : 0;
      ptr += esize[i];
    end

    wr(0, 0, 1, 5);
    for (int i = 1; i <= 15; i++) begin
      wr(i, VEC[i-1][11], VEC[i-1][10], int'(VEC[i-1][9:0]));
      if (i == 14) eq("R5 done before last", int'(cfg_done), 0);
    end
    eq("R5 done after last", int'(cfg_done), 1);
    eq("R5 err clean", int'(cfg_err), 0);
    eq("R8 hidden before enumeration", int'(ep_en), 1);
    eq("R8 hidden size ep6", int'(ep_size[6*10 +: 10]), 0);
    enumerated = 1;
    @(negedge clk);
    for (int k = 1; k <= 15; k++) begin
      eq($sformatf("R3 base ep%0d", k), int'(ep_base[k*12 +: 12]), ebase[k]);
      eq($sformatf("R4 size ep%0d", k), int'(ep_size[k*10 +: 10]), esize[k]);
      eq($sformatf("R4 enable ep%0d", k), int'(ep_en[k]), int'(VEC[k-1][11]));
      eq($sformatf("R9 dir ep%0d", k), int'(ep_dir[k]), int'(VEC[k-1][11] & VEC[k-1][10]));
    end
    ctrl_check("R2 ep0 after sequence");

    wr(5, 1, 0, 8);
    eq("R6 write after done err", int'(cfg_err), 1);
    eq("R6 write after done clears done", int'(cfg_done), 0);
    eq("R8 hidden on error", int'(ep_en), 1);

    wr(0, 0, 1, 3);
    eq("R2 restart clears err", int'(cfg_err), 0);
    eq("R2 restart done", int'(cfg_done), 0);
    ctrl_check("R2 restart");
    wr(1, 1, 0, 64);
    eq("R6 in order no err", int'(cfg_err), 0);
    wr(3, 1, 0, 64);
    eq("R6 out of order err", int'(cfg_err), 1);
    wr(2, 1, 0, 64);
    eq("R10 err sticky", int'(cfg_err), 1);
    repeat (4) @(negedge clk);
    eq("R10 err held idle", int'(cfg_err), 1);

    wr(0, 0, 0, 0);
    wr(1, 1, 0, 1023);
    eq("R7 first large fits", int'(cfg_err), 0);
    wr(2, 1, 1, 1023);
    eq("R7 overflow err", int'(cfg_err), 1);

    pulse_bus_rst();
    eq("R1 bus reset err", int'(cfg_err), 0);
    eq("R1 bus reset done", int'(cfg_done), 0);
    ctrl_check("R1 bus reset");

    wr(0, 0, 0, 0);
    for (int i = 1; i <= 15; i++) wr(i, 1, 1, 32);
    eq("R5 second sequence done", int'(cfg_done), 1);
    eq("R3 second base ep15", int'(ep_base[15*12 +: 12]), 64 + 14 * 32);
    pulse_bus_rst();
    eq("R1 bus reset after done", int'(cfg_done), 0);
    eq("R1 bus reset enables", int'(ep_en), 1);
    wr(1, 1, 0, 8);
    eq("R6 no restart after reset err", int'(cfg_err), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule